// File: doc/BRIEF.md
# Mode Unlock Sequence Detector

This block sits on a byte-wide register bus beside a multi-port input controller. After reset it holds the controller in a basic mode: only the input levels are read, and event sensing, interrupts and debounce are all off. The extended mode can be reached only by writing one exact four-byte key to the control port. The control port is port 7, and each port n sits at the even byte address 2n, so the control port is at 0Eh. The key must be written on consecutive bus accesses, must start soon after reset, and must be written while interrupts are disabled. Any fault in that procedure disarms the unlock until the next reset.

The same control port has a second job. In basic mode it holds a four-bit write mask, one bit for each of ports 0 to 3. In extended mode bits 7:6 of a write choose which of the three register banks is visible. A read of the port returns whichever of the two settings applies in the current mode. When the unlock completes, a one-cycle pulse is raised.

Top module: `mode_unlock`

## Requirements
- R1: While reset is held and on the first cycle after it, ext_mode is 0, bank_sel is 0, wr_mask is 0 and unlock_pulse is 0.
- R2: Writing 07h, 0Dh, 06h and 12h, in that order, to byte address 0Eh with irq_en low sets ext_mode in the cycle after the fourth write. Idle cycles with neither rd nor wr are allowed between the writes.
- R3: unlock_pulse is high for exactly one cycle, and that cycle is the first cycle in which ext_mode reads 1.
- R4: In basic mode, while the unlock is still armed, any of the following disarms it until the next reset, so that a correct key written later does not unlock: a write to 0Eh of a byte other than the next key byte; a read or write at any other address, odd addresses included; or a key write made while irq_en is high.
- R5: A read of 0Eh (rd high, wr low) in the middle of the key neither advances nor breaks the sequence.
- R6: The first key byte is accepted only on the clock edges numbered 0 to START_WINDOW-1 after reset is released. Once the window closes with no key byte accepted, the unlock is disarmed.
- R7: In basic mode, a write to 0Eh sets wr_mask to wdata[3:0] and ignores wdata[7:4]. A read of 0Eh returns {4'b0000, wr_mask}.
- R8: The write that completes the key clears wr_mask and bank_sel to 0. In extended mode, a write to 0Eh loads bank_sel from wdata[7:6] if that value is 0, 1 or 2. The value 3 is ignored, and wdata[5:0] has no effect. wr_mask stays 0. A read of 0Eh returns {bank_sel, 6'b000000}.
- R9: Once set, ext_mode stays 1 until reset whatever the bus does. Writing the key again produces no further pulse.
- R10: rdata is 00h whenever rd is low or the address is not 0Eh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the bus access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| irq_en | input | 1 | High while controller interrupts are enabled |
| rdata | output | 8 | Read data of the control port |
| ext_mode | output | 1 | 1 in extended mode |
| bank_sel | output | 2 | Selected register bank |
| wr_mask | output | 4 | Per-port write mask for ports 0 to 3 |
| unlock_pulse | output | 1 | One-cycle pulse on entering extended mode |

## Verification
The hardest situation to reach is the boundary of the start window. A single cycle decides whether the first key byte is accepted, so the bench releases reset and then waits exactly START_WINDOW-1 idle cycles, and in a separate run exactly START_WINDOW idle cycles, before it writes the key. It also interrupts partial keys in each of the ways that disarm: a wrong byte, a foreign address, an odd address and an enabled interrupt. After each interruption it writes the complete key, so that the disarm can be seen at the ports. The reference model keeps its own count of cycles since reset and is compared with the outputs on every clock.

// File: rtl/mun_pkg.sv
package mun_pkg;
   localparam int KEY_LEN   = 4;
   localparam int KEY_IDX_W = $clog2(KEY_LEN);

   typedef struct packed {
      logic       rd;
      logic       wr;
      logic       at_ctrl;
      logic [7:0] data;
   } bus_req_t;

   function automatic logic [7:0] key_byte(input logic [KEY_IDX_W-1:0] idx);
      logic [7:0] b;
      case (idx)
         2'd0:    b = 8'h07;
         2'd1:    b = 8'h0D;
         2'd2:    b = 8'h06;
         default: b = 8'h12;
      endcase
      return b;
   endfunction
endpackage

// File: rtl/mun_seq_track.sv
module mun_seq_track
   import mun_pkg::*;
#(
   parameter int START_WINDOW = 16
) (
   input  logic     clk,
   input  logic     rst,
   input  bus_req_t req,
   input  logic     irq_en,
   output logic     ext_mode,
   output logic     unlock_now,
   output logic     unlock_pulse
);
   localparam int CW = $clog2(START_WINDOW + 1);
   localparam logic [CW-1:0] WIN_C = CW'(START_WINDOW);
   localparam logic [KEY_IDX_W-1:0] LAST_IDX = KEY_IDX_W'(KEY_LEN - 1);

   logic [CW-1:0]        cnt_q;
   logic [KEY_IDX_W-1:0] idx_q;
   logic                 armed_q, ext_q, pulse_q;
   logic                 live, window_over, first_ok, match, access, benign;

   always_comb begin
      live        = armed_q && !ext_q;
      window_over = (cnt_q == WIN_C);
      first_ok    = (idx_q != '0) || !window_over;
      access      = req.rd || req.wr;
      benign      = req.rd && !req.wr && req.at_ctrl;
      match       = req.wr && req.at_ctrl && !irq_en &&
                    (req.data == key_byte(idx_q)) && first_ok;
      unlock_now  = live && match && (idx_q == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         idx_q   <= '0;
         armed_q <= 1'b1;
         ext_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= unlock_now;
         if (!window_over) cnt_q <= cnt_q + 1'b1;
         if (live) begin
            if (match) begin
               if (idx_q == LAST_IDX) ext_q <= 1'b1;
               else                   idx_q <= idx_q + 1'b1;
            end else if (access && !benign) begin
               armed_q <= 1'b0;
               idx_q   <= '0;
            end else if ((idx_q == '0) && window_over) begin
               armed_q <= 1'b0;
            end
         end
      end
   end

   assign ext_mode     = ext_q;
   assign unlock_pulse = pulse_q;

   assert_ext_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      ext_q |=> ext_q);
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
      pulse_q |=> !pulse_q);
   assert_disarm_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (!armed_q && !ext_q) |=> !ext_q);
endmodule

// File: rtl/mun_bank_reg.sv
module mun_bank_reg
   import mun_pkg::*;
#(
   parameter int NUM_BANKS = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  bus_req_t   req,
   input  logic       ext_mode,
   input  logic       unlock_now,
   output logic [3:0] mask,
   output logic [1:0] bank
);
   localparam logic [1:0] LAST_BANK = 2'(NUM_BANKS - 1);

   logic [3:0] mask_q;
   logic [1:0] bank_q;
   logic       wr_ctrl;
   logic       unused_bits;

   assign wr_ctrl     = req.wr && req.at_ctrl;
   assign unused_bits = ^req.data[5:4];

   always_ff @(posedge clk) begin
      if (rst || unlock_now) begin
         mask_q <= '0;
         bank_q <= '0;
      end else if (wr_ctrl) begin
         if (ext_mode) begin
            if (req.data[7:6] <= LAST_BANK) bank_q <= req.data[7:6];
         end else begin
            mask_q <= req.data[3:0];
         end
      end
   end

   assign mask = mask_q;
   assign bank = bank_q;

   assert_bank_range_R8: assert property (@(posedge clk) disable iff (rst)
      bank_q <= LAST_BANK);
   assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      ext_mode |-> (mask_q == 4'h0));
endmodule

// File: rtl/mode_unlock.sv
module mode_unlock
   import mun_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int CTRL_PORT    = 7,
   parameter int START_WINDOW = 16,
   parameter int NUM_BANKS    = 3,
   parameter int READ_REG     = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [7:0]        wdata,
   input  logic              irq_en,
   output logic [7:0]        rdata,
   output logic              ext_mode,
   output logic [1:0]        bank_sel,
   output logic [3:0]        wr_mask,
   output logic              unlock_pulse
);
   localparam int CTRL_ADDR = CTRL_PORT * 2;

   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("control port address does not fit in ADDR_W");
   end
   if (START_WINDOW < 1) begin : g_bad_win
      $error("START_WINDOW must be at least 1");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("NUM_BANKS must be 1 to 4");
   end
   if (READ_REG != 0 && READ_REG != 1) begin : g_bad_rreg
      $error("READ_REG must be 0 or 1");
   end

   bus_req_t   req;
   logic       unlock_now;
   logic [7:0] status;

   always_comb begin
      req.rd      = rd;
      req.wr      = wr;
      req.at_ctrl = (addr == ADDR_W'(CTRL_ADDR));
      req.data    = wdata;
   end

   mun_seq_track #(.START_WINDOW(START_WINDOW)) i_track (
      .clk          (clk),
      .rst          (rst),
      .req          (req),
      .irq_en       (irq_en),
      .ext_mode     (ext_mode),
      .unlock_now   (unlock_now),
      .unlock_pulse (unlock_pulse)
   );

   mun_bank_reg #(.NUM_BANKS(NUM_BANKS)) i_bank (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .ext_mode   (ext_mode),
      .unlock_now (unlock_now),
      .mask       (wr_mask),
      .bank       (bank_sel)
   );

   always_comb begin
      status = ext_mode ? {bank_sel, 6'b000000} : {4'b0000, wr_mask};
   end

   if (READ_REG == 1) begin : g_rd_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk) begin
         if (rst) rdata_q <= '0;
         else     rdata_q <= (rd && req.at_ctrl) ? status : 8'h00;
      end
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = (rd && req.at_ctrl) ? status : 8'h00;
   end

   assert_pulse_with_mode_R3: assert property (@(posedge clk) disable iff (rst)
      unlock_pulse |-> ext_mode);
endmodule

// File: tb/test_mode_unlock.sv
module test_mode_unlock;
   localparam int WIN = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0, irq_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ext_mode, unlock_pulse;
   logic [1:0] bank_sel;
   logic [3:0] wr_mask;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   int m_ext, m_pulse, m_bank, m_mask, m_armed, m_idx, m_cyc;
   byte unsigned key[$] = '{8'h07, 8'h0D, 8'h06, 8'h12};

   always #10 clk = ~clk;

   mode_unlock #(.START_WINDOW(WIN)) i_mode_unlock (
      .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
      .irq_en(irq_en), .rdata(rdata), .ext_mode(ext_mode),
      .bank_sel(bank_sel), .wr_mask(wr_mask), .unlock_pulse(unlock_pulse)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      chk(req, "ext_mode", ext_mode, m_ext);
      chk(req, "unlock_pulse", unlock_pulse, m_pulse);
      chk(req, "bank_sel", bank_sel, m_bank);
      chk(req, "wr_mask", wr_mask, m_mask);
   endtask

   task automatic model_reset();
      m_ext = 0; m_pulse = 0; m_bank = 0; m_mask = 0;
      m_armed = 1; m_idx = 0; m_cyc = 0;
   endtask

   // one bus cycle: drive at falling edge, check read data, update model at the edge
   task automatic step(input string req, input bit r, input bit w,
                       input int a, input int d, input bit irq = 0);
      int exp_rd;
      bit was_ext, unl, ctrl;
      rd = r; wr = w; addr = 6'(a); wdata = 8'(d); irq_en = irq;
      #1;
      ctrl = (a == 'h0E);
      exp_rd = (r && ctrl) ? (m_ext ? (m_bank << 6) : m_mask) : 0;
      chk(req, "rdata", rdata, exp_rd);
      @(posedge clk);
      was_ext = m_ext; unl = 0; m_pulse = 0;
      if (!m_ext && m_armed) begin
         if (w && ctrl && !irq && d == key[m_idx] && (m_idx != 0 || m_cyc < WIN)) begin
            if (m_idx == 3) begin
               unl = 1; m_ext = 1; m_pulse = 1; m_mask = 0; m_bank = 0;
            end else m_idx++;
         end else if ((r || w) && !(r && !w && ctrl)) begin
            m_armed = 0; m_idx = 0;
         end else if (m_idx == 0 && m_cyc >= WIN) m_armed = 0;
      end
      if (w && ctrl && !unl) begin
         if (was_ext) begin
            if (((d >> 6) & 3) < 3) m_bank = (d >> 6) & 3;
         end else m_mask = d & 'hF;
      end
      if (m_cyc < WIN) m_cyc++;
      @(negedge clk);
      chk_regs(req);
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; rd = 0; wr = 0; irq_en = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      model_reset();
      chk_regs("R1");
      rst = 0;
   endtask

   task automatic write_key(input string req);
      for (int i = 0; i < 4; i++) step(req, 0, 1, 'h0E, key[i]);
   endtask

   initial begin
      do_reset();
      step("R1", 0, 0, 0, 0);
      step("R10", 1, 0, 'h0E, 0);
      step("R10", 1, 0, 'h04, 0);          // read elsewhere also disarms
      write_key("R4");
      chk("R4", "ext after disarmed key", ext_mode, 0);

      // R7: mask in basic mode, upper bits ignored
      do_reset();
      step("R7", 0, 1, 'h0E, 'hF5);
      step("R7", 1, 0, 'h0E, 0);
      step("R7", 0, 1, 'h0E, 'hAA);
      step("R7", 1, 0, 'h0E, 0);

      // R2/R3/R5: key with idle gaps and a port-7 read in the middle
      do_reset();
      step("R2", 0, 1, 'h0E, 'h07);
      idle("R2", 3);
      step("R5", 1, 0, 'h0E, 0);
      step("R2", 0, 1, 'h0E, 'h0D);
      step("R2", 0, 1, 'h0E, 'h06);
      step("R3", 0, 1, 'h0E, 'h12);
      chk("R2", "ext after key", ext_mode, 1);
      chk("R3", "pulse after key", unlock_pulse, 1);
      step("R3", 0, 0, 0, 0);
      chk("R3", "pulse drops", unlock_pulse, 0);
      // R8: bank selection
      step("R8", 0, 1, 'h0E, 'h80);
      step("R8", 1, 0, 'h0E, 0);
      step("R8", 0, 1, 'h0E, 'hC0);
      chk("R8", "bank 3 ignored", bank_sel, 2);
      step("R8", 0, 1, 'h0E, 'h7F);
      step("R8", 1, 0, 'h0E, 0);
      step("R8", 0, 1, 'h0E, 'h00);
      chk("R8", "00h selects bank 0", bank_sel, 0);
      // R9: sticky mode, no repeated pulse
      step("R9", 0, 1, 'h02, 'h55);
      step("R9", 1, 0, 'h0F, 0);
      write_key("R9");
      step("R10", 1, 0, 'h0C, 0);

      // R4: abort by foreign port write
      do_reset();
      step("R4", 0, 1, 'h0E, 'h07);
      step("R4", 0, 1, 'h0E, 'h0D);
      step("R4", 0, 1, 'h02, 'h06);
      write_key("R4");
      chk("R4", "no unlock after foreign write", ext_mode, 0);

      // R4: odd address abort
      do_reset();
      step("R4", 0, 1, 'h0E, 'h07);
      step("R4", 1, 0, 'h0F, 0);
      write_key("R4");

      // R4: wrong byte then restart
      do_reset();
      step("R4", 0, 1, 'h0E, 'h07);
      step("R4", 0, 1, 'h0E, 'h07);
      write_key("R4");

      // R4: interrupts enabled during the key
      do_reset();
      step("R4", 0, 1, 'h0E, 'h07);
      step("R4", 0, 1, 'h0E, 'h0D, 1);
      write_key("R4");
      chk("R4", "no unlock with irq", ext_mode, 0);

      // R6: window boundary
      do_reset();
      idle("R6", WIN - 1);
      write_key("R6");
      chk("R6", "unlock at last window edge", ext_mode, 1);
      do_reset();
      idle("R6", WIN);
      write_key("R6");
      chk("R6", "no unlock after window", ext_mode, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule